// File: doc/BRIEF.md
# Integer ALU with Set-on-Compare

This block is the combinational integer execution stage of a simple load/store processor. In one pass it takes two 32-bit operands, a 5-bit operation selector, a flag choosing the immediate path and the raw 16-bit immediate field of the instruction. From these it produces a 32-bit result and a flag for signed arithmetic overflow. The operations are signed and unsigned addition and subtraction, bitwise AND, OR and XOR, placing the immediate in the upper half of a word, three kinds of shift, and six comparisons that return 0 or 1.

When `use_imm` is high, the second operand comes from the immediate field. The extension depends on the operation: the bitwise operations pad the immediate with zeros, and arithmetic and compare operations copy its top bit into the upper bits. The overflow output is meant to drive the exception logic of the pipeline. The result still shows the wrapped value when overflow is flagged.

Top module: `int_exec_alu`

## Requirements
- R1: Selector 0 (signed add) and 1 (unsigned add) give the 32-bit sum modulo 2^32. Selector 2 (signed subtract) and 3 (unsigned subtract) give the first operand minus the second, modulo 2^32.
- R2: With selector 0 or 2, `ovf` is 1 exactly when the true signed result falls outside the range -2^31 to 2^31-1.
- R3: For every selector other than 0 and 2, including unsigned add and subtract, `ovf` is 0.
- R4: Selectors 4 (AND), 5 (OR) and 6 (XOR) with `use_imm` high zero-extend the immediate to 32 bits before the bitwise operation.
- R5: Add and subtract selectors 0 to 3 with `use_imm` high sign-extend the immediate (bit 15 copied into bits 31..16).
- R6: Selector 7 puts the immediate in bits 31..16 of the result and zeros in bits 15..0, whatever `use_imm` and the operands hold.
- R7: For shifts, only bits 4..0 of the second operand (register or sign-extended immediate) set the shift amount. Higher bits have no effect.
- R8: Selector 8 shifts left and fills with zeros. Selector 9 shifts right and fills with zeros. Selector 10 shifts right and fills with copies of bit 31.
- R9: Selectors 11 (less-than), 12 (greater-than), 13 (less-or-equal), 14 (greater-or-equal), 15 (equal) and 16 (not-equal) compare the operands as signed two's-complement numbers. They return 32'd1 when the comparison is true and 32'd0 when it is false.
- R10: Compare selectors with `use_imm` high sign-extend the immediate before comparing.
- R11: Selectors 17 to 31 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 32 | First operand |
| opd_b | input | 32 | Second operand from a register |
| op | input | 5 | Operation selector |
| use_imm | input | 1 | Take the second operand from the immediate |
| imm | input | 16 | Raw immediate field |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed add or subtract overflow |

## Verification
The result and the overflow flag are produced together, so for signed add and subtract the bench checks the wrapped sum and the overflow flag on the same input vector. It drives edge pairs such as 0x7FFFFFFF plus 1 and 0x80000000 minus 1 through both the signed and the unsigned selectors. Immediate extension and the operation also act on the same vector: a negative immediate is fed to AND, to add and to a compare. The bench then checks that the upper half is cleared for AND and filled with ones for add and compare. Both outputs are compared against a behavioural model on every clock.

// File: rtl/int_exec_alu.sv
module int_exec_alu #(
  parameter int W   = 32,
  parameter int IW  = 16,
  parameter int OPW = 5
) (
  input  logic [W-1:0]   opd_a,
  input  logic [W-1:0]   opd_b,
  input  logic [OPW-1:0] op,
  input  logic           use_imm,
  input  logic [IW-1:0]  imm,
  output logic [W-1:0]   result,
  output logic           ovf
);
  localparam int SHW = $clog2(W);
  localparam logic [OPW-1:0] OP_ADD  = OPW'(0);
  localparam logic [OPW-1:0] OP_ADDU = OPW'(1);
  localparam logic [OPW-1:0] OP_SUB  = OPW'(2);
  localparam logic [OPW-1:0] OP_SUBU = OPW'(3);
  localparam logic [OPW-1:0] OP_AND  = OPW'(4);
  localparam logic [OPW-1:0] OP_OR   = OPW'(5);
  localparam logic [OPW-1:0] OP_XOR  = OPW'(6);
  localparam logic [OPW-1:0] OP_HIGH = OPW'(7);
  localparam logic [OPW-1:0] OP_SLL  = OPW'(8);
  localparam logic [OPW-1:0] OP_SRL  = OPW'(9);
  localparam logic [OPW-1:0] OP_SRA  = OPW'(10);
  localparam logic [OPW-1:0] OP_LT   = OPW'(11);
  localparam logic [OPW-1:0] OP_GT   = OPW'(12);
  localparam logic [OPW-1:0] OP_LE   = OPW'(13);
  localparam logic [OPW-1:0] OP_GE   = OPW'(14);
  localparam logic [OPW-1:0] OP_EQ   = OPW'(15);
  localparam logic [OPW-1:0] OP_NE   = OPW'(16);

  logic [W-1:0]   sext, zext, opb, sum, dif;
  logic           bitwise, lt, eq;
  logic [SHW-1:0] shamt;

  assign sext    = {{(W-IW){imm[IW-1]}}, imm};
  assign zext    = {{(W-IW){1'b0}}, imm};
  assign bitwise = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign opb     = use_imm ? (bitwise ? zext : sext) : opd_b;
  assign sum     = opd_a + opb;
  assign dif     = opd_a - opb;
  assign lt      = $signed(opd_a) < $signed(opb);
  assign eq      = opd_a == opb;
  assign shamt   = opb[SHW-1:0];

  always_comb begin
    case (op)
      OP_ADD, OP_ADDU: result = sum;
      OP_SUB, OP_SUBU: result = dif;
      OP_AND:  result = opd_a & opb;
      OP_OR:   result = opd_a | opb;
      OP_XOR:  result = opd_a ^ opb;
      OP_HIGH: result = {imm, {(W-IW){1'b0}}};
      OP_SLL:  result = opd_a << shamt;
      OP_SRL:  result = opd_a >> shamt;
      OP_SRA:  result = W'($signed(opd_a) >>> shamt);
      OP_LT:   result = {{(W-1){1'b0}}, lt};
      OP_GT:   result = {{(W-1){1'b0}}, !lt && !eq};
      OP_LE:   result = {{(W-1){1'b0}}, lt || eq};
      OP_GE:   result = {{(W-1){1'b0}}, !lt};
      OP_EQ:   result = {{(W-1){1'b0}}, eq};
      OP_NE:   result = {{(W-1){1'b0}}, !eq};
      default: result = '0;
    endcase
  end

  assign ovf = ((op == OP_ADD) && (opd_a[W-1] == opb[W-1]) && (sum[W-1] != opd_a[W-1])) ||
               ((op == OP_SUB) && (opd_a[W-1] != opb[W-1]) && (dif[W-1] != opd_a[W-1]));
endmodule

// File: rtl/int_exec_alu_chk.sv
module int_exec_alu_chk #(
  parameter int W   = 32,
  parameter int IW  = 16,
  parameter int OPW = 5
) (
  input logic [W-1:0]   opd_a,
  input logic [W-1:0]   opd_b,
  input logic [OPW-1:0] op,
  input logic           use_imm,
  input logic [IW-1:0]  imm,
  input logic [W-1:0]   result,
  input logic           ovf
);
  logic [4:0] amt;
  assign amt = use_imm ? imm[4:0] : opd_b[4:0];

  always_comb begin
    if (op != OPW'(0) && op != OPW'(2))
      AST_NO_OVERFLOW: assert (!ovf); // R3
    if (op >= OPW'(11) && op <= OPW'(16))
      AST_CMP_BOOL: assert (result[W-1:1] == '0); // R9
    if (op == OPW'(7))
      AST_HIGH_IMM: assert (result == {imm, {(W-IW){1'b0}}}); // R6
    if (op == OPW'(4) && use_imm)
      AST_AND_IMM_ZEXT: assert (result[W-1:IW] == '0); // R4
    if (op > OPW'(16))
      AST_UNUSED_ZERO: assert (result == '0); // R11
    if (op >= OPW'(8) && op <= OPW'(10) && amt == 5'd0)
      AST_SHIFT_ZERO: assert (result == opd_a); // R7
  end
endmodule

bind int_exec_alu int_exec_alu_chk #(.W(W), .IW(IW), .OPW(OPW)) i_chk (.*);

// File: tb/test_int_exec_alu.sv
module test_int_exec_alu;
  logic        clk = 1'b0;
  logic [31:0] opd_a = '0, opd_b = '0;
  logic [4:0]  op = '0;
  logic        use_imm = 1'b0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        ovf;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  int_exec_alu i_int_exec_alu (.opd_a(opd_a), .opd_b(opd_b), .op(op), .use_imm(use_imm),
                               .imm(imm), .result(result), .ovf(ovf));

  function automatic string tag_of(input logic [4:0] o, input logic im);
    if (o <= 3)  return im ? "R5" : "R1";
    if (o <= 6)  return im ? "R4" : "R1";
    if (o == 7)  return "R6";
    if (o <= 10) return im ? "R7" : "R8";
    if (o <= 16) return im ? "R10" : "R9";
    return "R11";
  endfunction

  task automatic model(output logic [31:0] r, output logic o);
    logic [31:0] b;
    longint      s;
    int          sh;
    o = 1'b0;
    if (!use_imm) b = opd_b;
    else if (op >= 4 && op <= 6) b = {16'h0, imm};
    else b = 32'($signed(imm));
    sh = int'(b % 32);
    case (op)
      0, 1: begin
        s = longint'($signed(opd_a)) + longint'($signed(b));
        r = opd_a + b;
        o = (op == 0) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end
      2, 3: begin
        s = longint'($signed(opd_a)) - longint'($signed(b));
        r = opd_a - b;
        o = (op == 2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end
      4: r = opd_a & b;
      5: r = opd_a | b;
      6: r = opd_a ^ b;
      7: r = {imm, 16'h0};
      8, 9, 10: begin
        r = opd_a;
        for (int k = 0; k < sh; k++) begin
          if (op == 8) r = {r[30:0], 1'b0};
          else r = {(op == 10) ? r[31] : 1'b0, r[31:1]};
        end
      end
      11: r = 32'($signed(opd_a) <  $signed(b));
      12: r = 32'($signed(opd_a) >  $signed(b));
      13: r = 32'($signed(opd_a) <= $signed(b));
      14: r = 32'($signed(opd_a) >= $signed(b));
      15: r = 32'(opd_a == b);
      16: r = 32'(opd_a != b);
      default: r = '0;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d imm_mode=%0b actual=%h expected=%h", tag, op, use_imm, got, exp);
    end
  endtask

  task automatic apply(input logic [4:0] o, input logic im, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] i);
    logic [31:0] er;
    logic        eo;
    @(posedge clk);
    op = o; use_imm = im; opd_a = a; opd_b = b; imm = i;
    @(negedge clk);
    model(er, eo);
    check(tag_of(o, im), result, er);
    check((o == 0 || o == 2) ? "R2" : "R3", {31'h0, ovf}, {31'h0, eo});
  endtask

  initial begin
    @(negedge clk);
    check("R1 reset-state", result, 32'h0);
    check("R3 reset-state", {31'h0, ovf}, 32'h0);
    apply(0, 0, 32'h7fffffff, 32'h1, 0);        // R2 positive wrap
    apply(1, 0, 32'h7fffffff, 32'h1, 0);        // R3 unsigned no flag
    apply(2, 0, 32'h80000000, 32'h1, 0);        // R2 negative wrap
    apply(3, 0, 32'h80000000, 32'h1, 0);        // R3
    apply(0, 0, 32'h80000000, 32'h80000000, 0); // R2
    apply(2, 0, 32'h0, 32'h80000000, 0);        // R2
    apply(4, 1, 32'hffffffff, 0, 16'h8001);     // R4 zero extend
    apply(5, 1, 32'h0, 0, 16'hf000);            // R4
    apply(0, 1, 32'h10, 0, 16'hffff);           // R5 sign extend
    apply(3, 1, 32'h10, 0, 16'h8000);           // R5
    apply(7, 0, 32'hdeadbeef, 32'h1234, 16'hff00); // R6
    apply(8, 0, 32'h1, 32'h21, 0);              // R7 amount 33 acts as 1
    apply(10, 1, 32'h80000000, 0, 16'hffe4);    // R7 imm amount 4
    apply(10, 0, 32'h80000010, 32'h4, 0);       // R8 arithmetic
    apply(9, 0, 32'h80000010, 32'h4, 0);        // R8 logical
    apply(11, 0, 32'hffffffff, 32'h1, 0);       // R9 signed less
    apply(12, 0, 32'hffffffff, 32'h1, 0);       // R9
    apply(13, 0, 32'h5, 32'h5, 0);              // R9
    apply(16, 0, 32'h5, 32'h5, 0);              // R9
    apply(11, 1, 32'h0, 0, 16'hffff);           // R10 0 < -1 false
    apply(14, 1, 32'hfffffffe, 0, 16'hffff);    // R10
    apply(15, 1, 32'hffff8000, 0, 16'h8000);    // R10
    apply(20, 0, 32'hffffffff, 32'hffffffff, 16'hffff); // R11
    for (int n = 0; n < 3000; n++)
      apply(5'($urandom_range(0, 31)), 1'($urandom), $urandom, $urandom, 16'($urandom));
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule